// File: doc/BRIEF.md
# Ethernet PHY Management Master with Reset Sequencing

The block drives the management bus of one or more Ethernet PHYs and owns their shared active-low reset line. After power-up, or whenever a reset is requested, it holds the PHY in reset for a long interval that can be stretched, so that strap inputs have time to settle. Slow-settling straps include pins that are AC coupled and discharge only through on-die pulldowns. It then releases reset and keeps the data line idle-high for a minimum number of management clocks before it accepts the first transaction.

After that it runs clause 22 read and write frames on command from a simple host-side request port. The management clock is divided down from the system clock, with one fast and one slow rate. The data line is open-drain: the block only ever pulls it low, and an external pullup supplies the ones. A read returns the 16 bits sampled from the PHY and a one-cycle done pulse. Because the PHY address field is 5 bits wide, the whole range 0 to 31 can be scanned. An address with no PHY behind it reads back as all ones.

Top module: `mdio_rst_ctrl`

## Requirements
- R1: After `rst_req_i` is sampled high, `phy_rst_no` goes low on that clock edge and stays low for exactly `2**RST_LOG2 << rst_len_sel_i` system clock cycles. The select value is captured with the request, and 2 gives the 4x stretch. Leaving system reset starts the same sequence with select 0.
- R2: The management clock has a high and low phase of `MDC_HALF_FAST` system cycles each when `mdc_slow_i` is 0, and `MDC_HALF_SLOW` cycles when it is 1. The defaults of 25 and 250 give 2.5 MHz and 250 kHz from 125 MHz.
- R3: While reset is held and during the quiet period, `mdc_o` keeps toggling and `mdio_pd_o` stays 0, so the line floats high.
- R4: After reset is released, `cmd_ready_o` stays 0 until `QUIET_MDC` (default 32) rising edges of `mdc_o` have occurred with `phy_rst_no` high. A command presented before then is stalled and not started.
- R5: A frame is sent MSB first, one bit per management clock period, and its line state changes only on falling edges of `mdc_o`. The bit order is: 32 ones, start bits 0 then 1, the opcode (binary 10 for read, 01 for write), the 5-bit PHY address, the 5-bit register address, 2 turnaround bits, and 16 data bits.
- R6: On a write, the turnaround bits are sent as 1 then 0, followed by `cmd_wdata_i`.
- R7: On a read, the master releases the line for the turnaround and data bits and samples the 16 data bits on rising edges of `mdc_o`. The value appears on `rdata_o`.
- R8: A read addressed to a PHY address with no responding device returns 16'hFFFF.
- R9: `busy_o` rises on the clock edge that accepts a command (`cmd_valid_i && cmd_ready_o`) and stays high until the frame's last bit has completed. `cmd_ready_o` is 0 while `busy_o` is 1.
- R10: `done_o` is a one-cycle pulse on the edge where `busy_o` falls at the end of a frame. `rdata_o` holds the read result from then on.
- R11: A reset request during a frame abandons it. `busy_o` falls without `done_o`, and `mdio_pd_o` is 0 whenever no frame is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Request a PHY reset sequence |
| rst_len_sel_i | input | 2 | Reset stretch select, length = base << value |
| mdc_slow_i | input | 1 | Select the slow management clock |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Command can be accepted |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_phy_i | input | 5 | PHY address |
| cmd_reg_i | input | 5 | Register address |
| cmd_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Frame complete pulse |
| rdata_o | output | 16 | Read result |
| phy_rst_no | output | 1 | PHY reset, active low |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | Management data line as seen at the pin |
| mdio_pd_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench builds the block with `MDC_HALF_FAST=2`, `MDC_HALF_SLOW=5`, `RST_LOG2=4` and the default `QUIET_MDC=32`. With these values a base reset is 16 cycles and the 4x stretch is 64 cycles, so the exact hold length can be counted for both settings. A frame spans a few hundred cycles, so reads and writes in both clock modes, an address scan miss, and a reset that cuts a frame short all fit in one run. The 32-edge quiet period is kept at its full default, so the stall of an early command is exercised at the real count.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int DATA_START = 48;

  typedef enum logic [1:0] {S_HOLD, S_QUIET, S_READY} seq_st_e;
  typedef enum logic [1:0] {F_IDLE, F_WAIT, F_RUN}    frm_st_e;

  // read frames load ones in turnaround and data so the line is released there
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic        wr,
    input logic [4:0]  phy,
    input logic [4:0]  rg,
    input logic [15:0] wd
  );
    return {{PRE_BITS{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
            (wr ? 2'b10 : 2'b11), (wr ? wd : 16'hFFFF)};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_FAST = 25,
  parameter int HALF_SLOW = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic mdc_o,
  output logic rise_stb_o,
  output logic fall_stb_o
);
  localparam int HMAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int CW   = $clog2(HMAX + 1);

  logic [CW-1:0] cnt_q, lim;
  logic          mdc_q, wrap;

  always_comb begin
    lim  = slow_i ? CW'(HALF_SLOW) : CW'(HALF_FAST);
    // >= keeps the divider sane if the rate changes mid-phase
    wrap = (cnt_q >= lim - CW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign mdc_o      = mdc_q;
  assign rise_stb_o = wrap & ~mdc_q;
  assign fall_stb_o = wrap &  mdc_q;
endmodule

// File: rtl/mdio_rst_seq.sv
module mdio_rst_seq
  import mdio_pkg::*;
#(
  parameter int RST_LOG2  = 16,
  parameter int QUIET_MDC = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [1:0] len_sel_i,
  input  logic       rise_stb_i,
  output logic       phy_rst_no,
  output logic       ready_o
);
  localparam int CW = RST_LOG2 + 4;
  localparam int QW = $clog2(QUIET_MDC + 1);

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q, lim;
  logic [1:0]    sel_q;
  logic [QW-1:0] qcnt_q;
  logic          rst_n_q;

  always_comb lim = (CW'(1) << (RST_LOG2 + 32'(sel_q))) - CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_HOLD;
      cnt_q   <= '0;
      sel_q   <= '0;
      qcnt_q  <= '0;
      rst_n_q <= 1'b0;
    end else if (req_i) begin
      st_q    <= S_HOLD;
      cnt_q   <= '0;
      sel_q   <= len_sel_i;
      rst_n_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_HOLD: begin
          if (cnt_q == lim) begin
            st_q    <= S_QUIET;
            rst_n_q <= 1'b1;
            qcnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        S_QUIET: begin
          if (rise_stb_i) begin
            if (qcnt_q == QW'(QUIET_MDC - 1)) st_q <= S_READY;
            else                               qcnt_q <= qcnt_q + QW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign phy_rst_no = rst_n_q;
  assign ready_o    = (st_q == S_READY);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        rise_stb_i,
  input  logic        fall_stb_i,
  input  logic        cmd_valid_i,
  input  logic        cmd_write_i,
  input  logic [4:0]  cmd_phy_i,
  input  logic [4:0]  cmd_reg_i,
  input  logic [15:0] cmd_wdata_i,
  output logic        cmd_ready_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  input  logic        mdio_i,
  output logic        mdio_pd_o
);
  localparam int BCW = $clog2(FRAME_BITS);

  frm_st_e               st_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [BCW-1:0]        bcnt_q;
  logic                  wr_q, pd_q, done_q;
  logic [15:0]           rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= F_IDLE;
      sh_q    <= '0;
      bcnt_q  <= '0;
      wr_q    <= 1'b0;
      pd_q    <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        st_q <= F_IDLE;
        pd_q <= 1'b0;
      end else begin
        unique case (st_q)
          F_IDLE: if (cmd_valid_i) begin
            sh_q <= build_frame(cmd_write_i, cmd_phy_i, cmd_reg_i, cmd_wdata_i);
            wr_q <= cmd_write_i;
            st_q <= F_WAIT;
          end
          F_WAIT: if (fall_stb_i) begin
            pd_q   <= ~sh_q[FRAME_BITS-1];
            sh_q   <= {sh_q[FRAME_BITS-2:0], 1'b1};
            bcnt_q <= '0;
            st_q   <= F_RUN;
          end
          F_RUN: begin
            if (rise_stb_i && !wr_q && (bcnt_q >= BCW'(DATA_START)))
              rdata_q <= {rdata_q[14:0], mdio_i};
            if (fall_stb_i) begin
              if (bcnt_q == BCW'(FRAME_BITS - 1)) begin
                pd_q   <= 1'b0;
                st_q   <= F_IDLE;
                done_q <= 1'b1;
              end else begin
                pd_q   <= ~sh_q[FRAME_BITS-1];
                sh_q   <= {sh_q[FRAME_BITS-2:0], 1'b1};
                bcnt_q <= bcnt_q + BCW'(1);
              end
            end
          end
          default: st_q <= F_IDLE;
        endcase
      end
    end
  end

  assign cmd_ready_o = en_i && (st_q == F_IDLE);
  assign busy_o      = (st_q != F_IDLE);
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign mdio_pd_o   = pd_q;
endmodule

// File: rtl/mdio_rst_ctrl.sv
module mdio_rst_ctrl #(
  parameter int MDC_HALF_FAST = 25,
  parameter int MDC_HALF_SLOW = 250,
  parameter int RST_LOG2      = 16,
  parameter int QUIET_MDC     = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rst_req_i,
  input  logic [1:0]  rst_len_sel_i,
  input  logic        mdc_slow_i,
  input  logic        cmd_valid_i,
  output logic        cmd_ready_o,
  input  logic        cmd_write_i,
  input  logic [4:0]  cmd_phy_i,
  input  logic [4:0]  cmd_reg_i,
  input  logic [15:0] cmd_wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        phy_rst_no,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_pd_o
);
  logic rise_stb, fall_stb, seq_ready;

  mdio_mdc_gen #(
    .HALF_FAST(MDC_HALF_FAST),
    .HALF_SLOW(MDC_HALF_SLOW)
  ) i_mdc_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slow_i    (mdc_slow_i),
    .mdc_o     (mdc_o),
    .rise_stb_o(rise_stb),
    .fall_stb_o(fall_stb)
  );

  mdio_rst_seq #(
    .RST_LOG2 (RST_LOG2),
    .QUIET_MDC(QUIET_MDC)
  ) i_rst_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (rst_req_i),
    .len_sel_i (rst_len_sel_i),
    .rise_stb_i(rise_stb),
    .phy_rst_no(phy_rst_no),
    .ready_o   (seq_ready)
  );

  mdio_frame_eng i_frame_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (seq_ready),
    .rise_stb_i (rise_stb),
    .fall_stb_i (fall_stb),
    .cmd_valid_i(cmd_valid_i),
    .cmd_write_i(cmd_write_i),
    .cmd_phy_i  (cmd_phy_i),
    .cmd_reg_i  (cmd_reg_i),
    .cmd_wdata_i(cmd_wdata_i),
    .cmd_ready_o(cmd_ready_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rdata_o    (rdata_o),
    .mdio_i     (mdio_i),
    .mdio_pd_o  (mdio_pd_o)
  );
endmodule

// File: rtl/mdio_rst_ctrl_chk.sv
module mdio_rst_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic cmd_ready_o,
  input logic busy_o,
  input logic done_o,
  input logic phy_rst_no,
  input logic mdc_o,
  input logic mdio_pd_o
);
  AST_RST_LINE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phy_rst_no && !$past(phy_rst_no)) |-> !mdio_pd_o); // R3
  AST_HOLD_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phy_rst_no |-> !cmd_ready_o); // R4
  AST_PD_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_rst_no && !$stable(mdio_pd_o)) |-> $fell(mdc_o)); // R5
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> busy_o); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cmd_ready_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdio_pd_o); // R11
endmodule

bind mdio_rst_ctrl mdio_rst_ctrl_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_ready_o(cmd_ready_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .phy_rst_no (phy_rst_no),
  .mdc_o      (mdc_o),
  .mdio_pd_o  (mdio_pd_o)
);

// File: tb/test_mdio_rst_ctrl.sv
`timescale 1ns/1ps
module test_mdio_rst_ctrl;
  localparam int HF = 2, HS = 5, RL2 = 4, QM = 32;
  localparam logic [4:0] PHY_ADDR = 5'd1;
  // {wr, slow, phy[4:0], reg[4:0], wdata[15:0], expected read[15:0]}
  localparam int NV = 10;
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'd1, 5'd3,  16'hA5C3, 16'h0000},
    {1'b0, 1'b0, 5'd1, 5'd3,  16'h0000, 16'hA5C3},
    {1'b0, 1'b0, 5'd1, 5'd5,  16'h0000, 16'h1005},
    {1'b1, 1'b1, 5'd1, 5'd31, 16'h0001, 16'h0000},
    {1'b0, 1'b1, 5'd1, 5'd31, 16'h0000, 16'h0001},
    {1'b0, 1'b0, 5'd7, 5'd0,  16'h0000, 16'hFFFF},
    {1'b1, 1'b0, 5'd9, 5'd2,  16'h1234, 16'h0000},
    {1'b0, 1'b0, 5'd1, 5'd2,  16'h0000, 16'h1002},
    {1'b1, 1'b0, 5'd1, 5'd0,  16'h8000, 16'h0000},
    {1'b0, 1'b0, 5'd1, 5'd0,  16'h0000, 16'h8000}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rst_req_i = 1'b0, mdc_slow_i = 1'b0, cmd_valid_i = 1'b0, cmd_write_i = 1'b0;
  logic [1:0] rst_len_sel_i = '0;
  logic [4:0] cmd_phy_i = '0, cmd_reg_i = '0;
  logic [15:0] cmd_wdata_i = '0;
  logic cmd_ready_o, busy_o, done_o, phy_rst_no, mdc_o, mdio_pd_o, mdio_line;
  logic [15:0] rdata_o;
  logic phy_drv = 1'b1;
  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  assign mdio_line = mdio_pd_o ? 1'b0 : phy_drv;

  mdio_rst_ctrl #(.MDC_HALF_FAST(HF), .MDC_HALF_SLOW(HS), .RST_LOG2(RL2), .QUIET_MDC(QM))
  i_mdio_rst_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_req_i(rst_req_i), .rst_len_sel_i(rst_len_sel_i),
    .mdc_slow_i(mdc_slow_i), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_write_i(cmd_write_i), .cmd_phy_i(cmd_phy_i), .cmd_reg_i(cmd_reg_i),
    .cmd_wdata_i(cmd_wdata_i), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .phy_rst_no(phy_rst_no), .mdc_o(mdc_o), .mdio_i(mdio_line), .mdio_pd_o(mdio_pd_o)
  );

  // PHY model: samples on MDC rise, drives on MDC fall
  logic [15:0] regs [32];
  int pst = 0, pcnt = 0, ones = 0, cap_n = 0;
  logic [11:0] hdr = '0, cap_hdr = '0;
  logic [17:0] wbits = '0, cap_w = '0;
  logic [15:0] rdval = '0;

  always @(posedge mdc_o or negedge phy_rst_no) begin
    if (!phy_rst_no) begin
      pst = 0; ones = 0;
    end else begin
      case (pst)
        0: if (mdio_line) ones++;
           else begin pst = (ones >= 32) ? 1 : 0; ones = 0; end
        1: if (mdio_line) begin pst = 2; pcnt = 0; end else pst = 0;
        2: begin
          hdr = {hdr[10:0], mdio_line}; pcnt++;
          if (pcnt == 12) begin
            pcnt = 0;
            if (hdr[11:10] == 2'b01) pst = 3;
            else if (hdr[11:10] == 2'b10 && hdr[9:5] == PHY_ADDR) begin
              pst = 4; rdval = regs[hdr[4:0]];
            end else pst = 5;
          end
        end
        3: begin
          wbits = {wbits[16:0], mdio_line}; pcnt++;
          if (pcnt == 18) begin
            cap_hdr = hdr; cap_w = wbits; cap_n++;
            if (hdr[9:5] == PHY_ADDR) regs[hdr[4:0]] = wbits[15:0];
            pst = 0;
          end
        end
        default: begin pcnt++; if (pcnt == 18) pst = 0; end
      endcase
    end
  end

  always @(negedge mdc_o or negedge phy_rst_no) begin
    if (!phy_rst_no) phy_drv = 1'b1;
    else if (pst == 4) begin
      if (pcnt == 0) phy_drv = 1'b1;
      else if (pcnt == 1) phy_drv = 1'b0;
      else phy_drv = rdval[17-pcnt];
    end else phy_drv = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic wait_ready();
    while (!cmd_ready_o) @(negedge clk_i);
  endtask

  task automatic finish_cmd(output logic [15:0] rd);
    bit bad = 0;
    while (!busy_o) @(negedge clk_i);
    cmd_valid_i = 1'b0;
    while (!done_o) begin
      if (!busy_o || cmd_ready_o) bad = 1;
      @(negedge clk_i);
    end
    check(!bad, "R9 busy held, ready low during frame", {31'd0, bad}, 0);
    check(!busy_o, "R10 busy falls with done", {31'd0, busy_o}, 0);
    rd = rdata_o;
    @(negedge clk_i);
    check(!done_o, "R10 done is one cycle", {31'd0, done_o}, 0);
  endtask

  task automatic start_cmd(input logic wr, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_write_i = wr; cmd_phy_i = phy; cmd_reg_i = rg; cmd_wdata_i = wd;
  endtask

  // reset request; optionally a read of reg 3 held pending through the sequence
  task automatic rst_test(input logic [1:0] sel, input bit with_cmd);
    int lowc = 0, tog = 0, rises = 0;
    bit bad_line = 0, bad_busy = 0;
    logic prev;
    logic [15:0] rd;
    @(negedge clk_i);
    rst_req_i = 1'b1; rst_len_sel_i = sel;
    if (with_cmd) begin cmd_valid_i = 1'b1; cmd_write_i = 1'b0; cmd_phy_i = PHY_ADDR; cmd_reg_i = 5'd3; end
    @(negedge clk_i);
    rst_req_i = 1'b0;
    prev = mdc_o;
    while (!phy_rst_no) begin
      lowc++;
      if (mdio_pd_o) bad_line = 1;
      if (mdc_o != prev) tog++;
      prev = mdc_o;
      @(negedge clk_i);
    end
    check(lowc == (16 << sel), "R1 reset hold length", lowc, 16 << sel);
    check(tog > 2, "R3 MDC toggles in reset", tog, 3);
    forever begin
      if (mdc_o && !prev) rises++;
      prev = mdc_o;
      if (cmd_ready_o) break;
      if (mdio_pd_o) bad_line = 1;
      if (busy_o) bad_busy = 1;
      @(negedge clk_i);
    end
    check(!bad_line, "R3 line released in reset and quiet", {31'd0, bad_line}, 0);
    check(rises >= QM, "R4 quiet MDC rises before ready", rises, QM);
    check(!bad_busy, "R4 command stalled until quiet ends", {31'd0, bad_busy}, 0);
    if (with_cmd) begin
      finish_cmd(rd);
      check(rd == 16'hA5C3, "R4 stalled read completes", {16'd0, rd}, 32'hA5C3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int hi;
    bit seen_done;
    for (int i = 0; i < 32; i++) regs[i] = 16'h1000 + 16'(i);
    repeat (3) @(negedge clk_i);
    check(!phy_rst_no, "R1 reset state phy_rst_no", {31'd0, phy_rst_no}, 0);
    check(!busy_o && !done_o && !cmd_ready_o, "R4 reset state control", {29'd0, busy_o, done_o, cmd_ready_o}, 0);
    check(!mdio_pd_o, "R11 reset state line", {31'd0, mdio_pd_o}, 0);
    rst_ni = 1'b1;
    wait_ready();

    for (int s = 0; s < 2; s++) begin
      mdc_slow_i = s[0];
      repeat (4 * HS) @(negedge clk_i);
      while (mdc_o) @(negedge clk_i);
      while (!mdc_o) @(negedge clk_i);
      hi = 0;
      while (mdc_o) begin hi++; @(negedge clk_i); end
      check(hi == (s ? HS : HF), "R2 MDC half period", hi, s ? HS : HF);
    end
    mdc_slow_i = 1'b0;

    for (int v = 0; v < NV; v++) begin
      int n0;
      logic [43:0] e;
      e = VEC[v];
      n0 = cap_n;
      mdc_slow_i = e[42];
      start_cmd(e[43], e[41:37], e[36:32], e[31:16]);
      finish_cmd(rd);
      if (e[43]) begin
        check(cap_n == n0 + 1, "R5 write frame recognised", cap_n, n0 + 1);
        check(cap_hdr == {2'b01, e[41:37], e[36:32]}, "R5 op and address fields", {20'd0, cap_hdr}, {20'd0, 2'b01, e[41:32]});
        check(cap_w == {2'b10, e[31:16]}, "R6 turnaround and data", {14'd0, cap_w}, {14'd0, 2'b10, e[31:16]});
      end else begin
        check(rd == e[15:0], e[41:37] == PHY_ADDR ? "R7 read data" : "R8 absent PHY reads ones", {16'd0, rd}, {16'd0, e[15:0]});
      end
    end
    mdc_slow_i = 1'b0;

    rst_test(2'd0, 1'b0);
    rst_test(2'd2, 1'b1);

    // R11: reset cuts a read short
    start_cmd(1'b0, PHY_ADDR, 5'd3, 16'h0);
    while (!busy_o) @(negedge clk_i);
    cmd_valid_i = 1'b0;
    seen_done = 0;
    repeat (60) begin @(negedge clk_i); if (done_o) seen_done = 1; end
    rst_req_i = 1'b1;
    @(negedge clk_i);
    rst_req_i = 1'b0;
    if (done_o) seen_done = 1;
    @(negedge clk_i);
    if (done_o) seen_done = 1;
    check(!busy_o, "R11 abort drops busy", {31'd0, busy_o}, 0);
    check(!mdio_pd_o, "R11 abort releases line", {31'd0, mdio_pd_o}, 0);
    check(!seen_done, "R11 no done on abort", {31'd0, seen_done}, 0);
    wait_ready();
    start_cmd(1'b0, PHY_ADDR, 5'd3, 16'h0);
    finish_cmd(rd);
    check(rd == 16'hA5C3, "R7 read after abort", {16'd0, rd}, 32'hA5C3);

    summary();
    $finish;
  end
endmodule